// File: doc/BRIEF.md
# Strobed Byte Receive Latch

This block is the receiving side of a byte-wide handshake link. A sender outside the clock domain places a byte on the data pins and pulses a strobe. The block brings the strobe into the local clock domain and detects the selected edge. On that edge it loads the byte into a holding register and raises an available flag. The same flag goes back to the sender as its busy line. The sender must wait for busy to go inactive before it strobes again.

The host consumes the byte by pulsing a clear-on-read input for one cycle. This drops the flag, and the sender may then send the next byte. Parameters select the strobe polarity, the edge that triggers capture, and the polarity of the busy output. With the default settings the strobe is active low and capture waits for its trailing (rising) edge. Selecting leading-edge capture loads the byte as soon as the strobe asserts, so the trailing-edge wait is gone. A strobe that arrives while the flag is still set overwrites the byte and raises a sticky overrun indication.

Top module: `byte_handshake_rx`

## Requirements
- R1: While reset is asserted and right after it is released, `avail` and `overrun` are 0, `dout` is all zeros and `busy` sits at its inactive level.
- R2: With `LEADING_EDGE_CAPTURE`=0, a strobe loads `din` into `dout` and sets `avail` only when the strobe is deasserted. A strobe held asserted captures nothing. Outputs update on the third rising clock edge after the strobe pin changes.
- R3: With `LEADING_EDGE_CAPTURE`=1, capture happens when the strobe asserts, while the strobe is still held.
- R4: `STB_ACTIVE_LOW`=1 treats a low strobe pin as asserted. `STB_ACTIVE_LOW`=0 treats a high strobe pin as asserted.
- R5: `busy` equals `avail` when `BUSY_ACTIVE_HIGH`=1 and equals the inverse of `avail` when `BUSY_ACTIVE_HIGH`=0.
- R6: A one-cycle `rd_clr` pulse with no capture in the same cycle clears `avail` on the next clock edge.
- R7: When `rd_clr` and a capture fall on the same clock edge, the capture wins: `avail` stays 1 and `dout` takes the new byte.
- R8: A capture while `avail` is 1 and `rd_clr` is low still loads the new byte and sets `overrun`. `overrun` stays set until an `rd_clr` pulse clears it. A capture coinciding with `rd_clr` does not set it.
- R9: A strobe pulse lasting two clock periods is captured.
- R10: `dout` changes only on a capture; `rd_clr` leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stb_in | input | 1 | Sender strobe, asynchronous, polarity set by parameter |
| din | input | DATA_W | Sender data, stable around the capturing edge |
| rd_clr | input | 1 | Host read pulse, clears the available and overrun flags |
| dout | output | DATA_W | Held received byte |
| avail | output | 1 | A byte is waiting for the host |
| busy | output | 1 | Flow-control line to the sender, polarity set by parameter |
| overrun | output | 1 | Sticky: a byte was overwritten before it was read |

## Verification
The bench builds two copies side by side. The first uses the defaults: an active-low strobe, trailing-edge capture and active-high busy. The second flips all three options: an active-high strobe, leading-edge capture and active-low busy. Driving both with the same kind of pulses shows that a held strobe captures only in the leading-edge copy, and that busy follows the flag in opposite senses. Both copies use a data width of 8 and two synchronizer stages. This allows the exact clear-versus-capture collision cycle to be hit, along with the two-period minimum pulse.

// File: rtl/bhrx_pkg.sv
package bhrx_pkg;
   localparam int unsigned MIN_SYNC_STAGES = 2;

   typedef struct packed {
      logic avail;
      logic overrun;
   } rx_flags_t;
endpackage

// File: rtl/bhrx_sync.sv
module bhrx_sync #(
   parameter int unsigned WIDTH   = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= {WIDTH{RST_VAL}};
      else        stg[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[i] <= {WIDTH{RST_VAL}};
         else        stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/bhrx_edge.sv
module bhrx_edge #(
   parameter bit ACTIVE_LOW = 1'b1,
   parameter bit LEADING    = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb_sync,
   output logic cap_pulse
);
   logic asserted;
   logic asserted_q;

   if (ACTIVE_LOW) begin : g_pol_low
      assign asserted = ~stb_sync;
   end else begin : g_pol_high
      assign asserted = stb_sync;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) asserted_q <= 1'b0;
      else        asserted_q <= asserted;
   end

   if (LEADING) begin : g_lead
      assign cap_pulse = asserted & ~asserted_q;
   end else begin : g_trail
      assign cap_pulse = ~asserted & asserted_q;
   end
endmodule

// File: rtl/bhrx_hold.sv
module bhrx_hold import bhrx_pkg::*; #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_pulse,
   input  logic [DATA_W-1:0] cap_data,
   input  logic              rd_clr,
   output logic [DATA_W-1:0] data_q,
   output rx_flags_t         flags_q
);
   rx_flags_t flags_d;

   always_comb begin
      flags_d = flags_q;
      if (rd_clr) begin
         flags_d.avail   = 1'b0;
         flags_d.overrun = 1'b0;
      end
      if (cap_pulse) begin
         if (flags_q.avail && !rd_clr) flags_d.overrun = 1'b1;
         flags_d.avail = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         flags_q <= '0;
      end else begin
         flags_q <= flags_d;
         if (cap_pulse) data_q <= cap_data;
      end
   end
endmodule

// File: rtl/byte_handshake_rx.sv
module byte_handshake_rx import bhrx_pkg::*; #(
   parameter int unsigned DATA_W               = 8,
   parameter int unsigned SYNC_STAGES          = 2,
   parameter bit          STB_ACTIVE_LOW       = 1'b1,
   parameter bit          LEADING_EDGE_CAPTURE = 1'b0,
   parameter bit          BUSY_ACTIVE_HIGH     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb_in,
   input  logic [DATA_W-1:0] din,
   input  logic              rd_clr,
   output logic [DATA_W-1:0] dout,
   output logic              avail,
   output logic              busy,
   output logic              overrun
);
   localparam logic STB_IDLE = STB_ACTIVE_LOW;

   if (DATA_W < 1) begin : g_bad_width
      $error("byte_handshake_rx: DATA_W must be at least 1");
   end
   if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_sync
      $error("byte_handshake_rx: SYNC_STAGES below minimum");
   end

   logic              stb_sync;
   logic [DATA_W-1:0] data_sync;
   logic              cap_pulse;
   rx_flags_t         flags;

   bhrx_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(STB_IDLE)) u_stb_sync (
      .clk(clk), .rst_n(rst_n), .d(stb_in), .q(stb_sync)
   );

   bhrx_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_data_sync (
      .clk(clk), .rst_n(rst_n), .d(din), .q(data_sync)
   );

   bhrx_edge #(.ACTIVE_LOW(STB_ACTIVE_LOW), .LEADING(LEADING_EDGE_CAPTURE)) u_edge (
      .clk(clk), .rst_n(rst_n), .stb_sync(stb_sync), .cap_pulse(cap_pulse)
   );

   bhrx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .cap_pulse(cap_pulse), .cap_data(data_sync),
      .rd_clr(rd_clr), .data_q(dout), .flags_q(flags)
   );

   assign avail   = flags.avail;
   assign overrun = flags.overrun;

   if (BUSY_ACTIVE_HIGH) begin : g_busy_high
      assign busy = flags.avail;
   end else begin : g_busy_low
      assign busy = ~flags.avail;
   end
endmodule

// File: rtl/bhrx_chk.sv
module bhrx_chk #(
   parameter int unsigned DATA_W           = 8,
   parameter bit          BUSY_ACTIVE_HIGH = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cap_pulse,
   input logic [DATA_W-1:0] cap_data,
   input logic              rd_clr,
   input logic [DATA_W-1:0] dout,
   input logic              avail,
   input logic              busy,
   input logic              overrun
);
   // R1
   always @(posedge clk) begin
      if (!rst_n) begin
         reset_state_chk: assert (!avail && !overrun && dout == '0);
      end
   end

   // R2
   cap_sets_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_pulse |=> avail);

   // R2
   cap_loads_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_pulse |=> dout == $past(cap_data));

   // R5
   busy_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy == (avail ~^ BUSY_ACTIVE_HIGH));

   // R6
   clr_drops_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_clr && !cap_pulse |=> !avail);

   // R7
   cap_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_clr && cap_pulse |=> avail);

   // R8
   overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_pulse && avail && !rd_clr |=> overrun);

   // R8
   overrun_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_clr |=> !overrun);

   // R10
   dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_pulse |=> $stable(dout));
endmodule

bind byte_handshake_rx bhrx_chk #(
   .DATA_W(DATA_W), .BUSY_ACTIVE_HIGH(BUSY_ACTIVE_HIGH)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cap_pulse(cap_pulse), .cap_data(data_sync),
   .rd_clr(rd_clr), .dout(dout), .avail(avail), .busy(busy), .overrun(overrun)
);

// File: tb/byte_handshake_rx_tb_top.sv
module byte_handshake_rx_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   // copy A: defaults (active-low strobe, trailing capture, busy high)
   logic       stb_a = 1'b1, rd_a = 1'b0;
   logic [7:0] din_a = '0, dout_a;
   logic       avail_a, busy_a, ovr_a;
   // copy B: active-high strobe, leading capture, busy low
   logic       stb_b = 1'b0, rd_b = 1'b0;
   logic [7:0] din_b = '0, dout_b;
   logic       avail_b, busy_b, ovr_b;

   byte_handshake_rx dut_i (
      .clk(clk), .rst_n(rst_n), .stb_in(stb_a), .din(din_a), .rd_clr(rd_a),
      .dout(dout_a), .avail(avail_a), .busy(busy_a), .overrun(ovr_a)
   );

   byte_handshake_rx #(.STB_ACTIVE_LOW(1'b0), .LEADING_EDGE_CAPTURE(1'b1),
                       .BUSY_ACTIVE_HIGH(1'b0)) dut_alt_i (
      .clk(clk), .rst_n(rst_n), .stb_in(stb_b), .din(din_b), .rd_clr(rd_b),
      .dout(dout_b), .avail(avail_b), .busy(busy_b), .overrun(ovr_b)
   );

   logic       ea_av = 0, ea_ov = 0, eb_av = 0, eb_ov = 0;
   logic [7:0] ea_d = '0, eb_d = '0;

   function automatic logic busy_of(logic av, logic high);
      return high ? av : ~av;
   endfunction

   function automatic logic ovr_after_cap(logic av, logic ov, logic rd);
      return rd ? 1'b0 : (ov | av);
   endfunction

   task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic check_a(string tag);
      check({tag, " A avail"}, {7'd0, avail_a}, {7'd0, ea_av});
      check({tag, " A data"}, dout_a, ea_d);
      check({tag, " A overrun"}, {7'd0, ovr_a}, {7'd0, ea_ov});
      check({"R5 ", tag, " A busy"}, {7'd0, busy_a}, {7'd0, busy_of(ea_av, 1'b1)});
   endtask

   task automatic check_b(string tag);
      check({tag, " B avail"}, {7'd0, avail_b}, {7'd0, eb_av});
      check({tag, " B data"}, dout_b, eb_d);
      check({tag, " B overrun"}, {7'd0, ovr_b}, {7'd0, eb_ov});
      check({"R5 ", tag, " B busy"}, {7'd0, busy_b}, {7'd0, busy_of(eb_av, 1'b0)});
   endtask

   // pulse both strobes for 'width' clock periods
   task automatic send_both(logic [7:0] a, logic [7:0] b, int width);
      @(negedge clk);
      din_a = a; stb_a = 1'b0;
      din_b = b; stb_b = 1'b1;
      repeat (width) @(negedge clk);
      stb_a = 1'b1; stb_b = 1'b0;
      ea_ov = ovr_after_cap(ea_av, ea_ov, 1'b0); ea_av = 1'b1; ea_d = a;
      eb_ov = ovr_after_cap(eb_av, eb_ov, 1'b0); eb_av = 1'b1; eb_d = b;
      repeat (4) @(negedge clk);
   endtask

   task automatic read_both();
      @(negedge clk);
      rd_a = 1'b1; rd_b = 1'b1;
      @(negedge clk);
      rd_a = 1'b0; rd_b = 1'b0;
      ea_av = 0; ea_ov = 0; eb_av = 0; eb_ov = 0;
      @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'h1D5E_ED01));
      repeat (3) @(negedge clk);
      // R1
      check_a("R1 in reset");
      check_b("R1 in reset");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_a("R1 after reset");
      check_b("R1 after reset");

      // R2 R3 R4: held strobe, only leading-edge copy captures
      @(negedge clk);
      din_a = 8'hA5; stb_a = 1'b0;
      din_b = 8'h3C; stb_b = 1'b1;
      repeat (6) @(negedge clk);
      eb_av = 1'b1; eb_d = 8'h3C;
      check_a("R2 held strobe no capture");
      check_b("R3 R4 leading capture while held");
      stb_a = 1'b1; stb_b = 1'b0;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      check({"R2 before third edge"}, {7'd0, avail_a}, 8'd0);
      @(negedge clk);
      ea_av = 1'b1; ea_d = 8'hA5;
      check_a("R2 R4 trailing capture at third edge");

      // R6 R10: read clears flag, keeps data
      read_both();
      check_a("R6 R10 read");
      check_b("R6 R10 read");

      // R8: second byte before read
      send_both(8'h11, 8'h22, 3);
      send_both(8'h99, 8'h88, 3);
      check_a("R8 overrun");
      check_b("R8 overrun");
      read_both();
      check_a("R8 overrun cleared by read");
      check_b("R8 overrun cleared by read");

      // R7: capture and clear on the same edge (copy A)
      send_both(8'h5A, 8'h6B, 3);
      @(negedge clk);
      din_a = 8'hC3; stb_a = 1'b0;
      repeat (3) @(negedge clk);
      stb_a = 1'b1;
      @(posedge clk); @(posedge clk);
      @(negedge clk); rd_a = 1'b1;
      @(negedge clk); rd_a = 1'b0;
      ea_av = 1'b1; ea_d = 8'hC3; ea_ov = ovr_after_cap(1'b1, ea_ov, 1'b1);
      repeat (2) @(negedge clk);
      check_a("R7 capture beats clear");
      read_both();

      // R9: minimum pulse width
      send_both(8'hF0, 8'h0F, 2);
      check_a("R9 two-period pulse");
      check_b("R9 two-period pulse");
      read_both();

      // random traffic
      for (int i = 0; i < 300; i++) begin
         send_both(8'($urandom), 8'($urandom), 2 + int'($urandom_range(0, 4)));
         check_a("R2 R8 random");
         check_b("R3 R8 random");
         if ($urandom_range(0, 1) == 1) begin
            read_both();
            check_a("R6 R10 random read");
            check_b("R6 R10 random read");
         end
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            vectors++;
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule